// File: doc/BRIEF.md
# Per-Function Virtual Register Window Decoder

This block decodes a flat memory-mapped window in which each PCI function owns a private set of 2048 dword virtual registers. The registers are split into two 4 KB pages. Page 0 is the page that the host intercepts. Page 1 is meant to be shared directly with the guest, and here it is reduced to a page-select output bit. Each request carries a byte offset, a length in bytes, a direction and write data. The block splits the offset into bus, device, function, page and register index, and then either forwards the access to a small per-function register store or turns it away.

Only aligned, full-dword accesses reach the store. A malformed access reads as zero, or is dropped if it is a write, and it raises a one-cycle error flag alongside its response. The host bridge address reads as zero and ignores writes. Functions that are absent, or that lie outside the store, also read as zero. This differs from the all-ones value returned on the ordinary configuration path. The store models `NUM_FUNCS` functions of one device on bus 0. Which of them exist is decided by a presence mask that is captured while reset is asserted. Each function implements `IMPL_REGS` registers per page.

Top module: `vreg_window`

## Requirements
- R1: The offset is decoded with bus at bits 28:21, device at bits 20:16, function at bits 15:13, page at bit 12 and register index at bits 11:2. A legal write followed by a read of the same offset returns the written word unchanged (bits 7:0 are byte 0). Pages and registers of each function are independent.
- R2: Every request gets exactly one response, with `rsp_valid` high one clock after the request cycle. No response is produced without a request.
- R3: An access is legal only when offset bits 1:0 are zero and `req_len` is 4. An illegal read returns 0 and an illegal write leaves the store unchanged; both set `rsp_err`.
- R4: `rsp_err` is high only together with `rsp_valid`, for one cycle per malformed request.
- R5: Legal accesses to bus 0, device 0, function 0 read 0, ignore writes and raise no error.
- R6: Legal accesses to an absent function read 0, discard writes and raise no error. An absent function is one whose presence bit is clear, whose function number is `NUM_FUNCS` or more, or whose bus or device differs from bus 0, device `TGT_DEV`. Such accesses never alias onto a present function.
- R7: `func_present` is sampled only while `rst_n` is low. Changes to it after reset have no effect.
- R8: `rsp_page` equals bit 12 of the request offset.
- R9: After reset `rsp_valid` and `rsp_err` are low and every stored register reads 0.
- R10: A legal access with a register index of `IMPL_REGS` or more reads 0, discards writes and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_present | input | NUM_FUNCS | Presence mask, bit k for function k, captured during reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 29 | Byte offset into the window |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Malformed-access pulse |
| rsp_page | output | 1 | Page select of the answered access |

## Verification
Two functions can fall in one request: the malformed-access check and the register store write, because a misaligned or short write can still decode to a present function's register. This case is provoked by issuing such writes in the middle of a back-to-back stream. The check is made at two points: the error pulse must appear on that response only, and a later legal read of the decoded register must return the earlier value. Out-of-range function numbers and register indices are judged in the same way, by reading back the function whose address they would alias onto if truncated.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
    localparam int OFF_W    = 29;
    localparam int LEN_W    = 3;
    localparam int DATA_W   = 32;
    localparam int BUS_W    = 8;
    localparam int DEV_W    = 5;
    localparam int FN_W     = 3;
    localparam int IDX_W    = 10;
    localparam int IDX_LSB  = 2;
    localparam int PAGE_BIT = 12;
    localparam int FN_LSB   = 13;
    localparam int DEV_LSB  = 16;
    localparam int BUS_LSB  = 21;
    localparam int DWORD_BYTES = 4;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic             page;
        logic [IDX_W-1:0] idx;
    } fields_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic              page;
        logic [DATA_W-1:0] rdata;
    } rsp_t;
endpackage

// File: rtl/vreg_decode.sv
module vreg_decode
    import vreg_pkg::*;
#(
    parameter int NUM_FUNCS = 4,
    parameter int IMPL_REGS = 4,
    parameter int TGT_DEV   = 1,
    parameter int SLOT_W    = 2,
    parameter int RIDX_W    = 2
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [LEN_W-1:0]  len,
    output logic              legal,
    output logic              is_root,
    output logic              hit,
    output logic              page,
    output logic [SLOT_W-1:0] slot,
    output logic [RIDX_W-1:0] ridx
);
    fields_t f;

    always_comb begin
        f.bus  = off[BUS_LSB +: BUS_W];
        f.dev  = off[DEV_LSB +: DEV_W];
        f.fn   = off[FN_LSB +: FN_W];
        f.page = off[PAGE_BIT];
        f.idx  = off[IDX_LSB +: IDX_W];

        legal   = (off[IDX_LSB-1:0] == '0) && (32'(len) == DWORD_BYTES);
        is_root = (f.bus == '0) && (f.dev == '0) && (f.fn == '0);
        hit     = (f.bus == '0) && (32'(f.dev) == TGT_DEV)
                  && (32'(f.fn) < NUM_FUNCS) && (32'(f.idx) < IMPL_REGS);
        page    = f.page;
        slot    = f.fn[SLOT_W-1:0];
        ridx    = f.idx[RIDX_W-1:0];
    end
endmodule

// File: rtl/vreg_store.sv
module vreg_store
    import vreg_pkg::*;
#(
    parameter int NUM_FUNCS = 4,
    parameter int SLOT_W    = 2,
    parameter int RIDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_FUNCS-1:0] present_in,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] a_slot,
    input  logic              a_page,
    input  logic [RIDX_W-1:0] a_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_present
);
    localparam int AW    = SLOT_W + 1 + RIDX_W;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [NUM_FUNCS-1:0]          present;
        logic [DEPTH-1:0][DATA_W-1:0]  mem;
    } store_t;

    store_t st_d, st_q;
    logic [AW-1:0] addr;
    logic          slot_present;

    always_comb begin
        addr         = {a_slot, a_page, a_idx};
        slot_present = (32'(a_slot) < NUM_FUNCS) && st_q.present[a_slot];
        st_d         = st_q;
        if (wr_en && slot_present) begin
            st_d.mem[addr] = wr_data;
        end
        rd_data    = st_q.mem[addr];
        rd_present = slot_present;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.present <= present_in;
            st_q.mem     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the captured presence mask never changes outside reset
    assert_present_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(st_q.present));

    // R6: a write to an absent slot leaves the addressed word alone
    assert_absent_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !slot_present) |=> (st_q.mem == $past(st_q.mem)));
endmodule

// File: rtl/vreg_window.sv
module vreg_window
    import vreg_pkg::*;
#(
    parameter int NUM_FUNCS = 4,
    parameter int IMPL_REGS = 4,
    parameter int TGT_DEV   = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FUNCS-1:0] func_present,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [28:0]          req_off,
    input  logic [2:0]           req_len,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic                 rsp_err,
    output logic                 rsp_page
);
    localparam int SLOT_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;
    localparam int RIDX_W = (IMPL_REGS > 1) ? $clog2(IMPL_REGS) : 1;

    logic              legal, is_root, hit, page;
    logic [SLOT_W-1:0] slot;
    logic [RIDX_W-1:0] ridx;
    logic              wr_en, rd_present;
    logic [DATA_W-1:0] rd_data;
    rsp_t              rsp_d, rsp_q;

    vreg_decode #(
        .NUM_FUNCS(NUM_FUNCS), .IMPL_REGS(IMPL_REGS), .TGT_DEV(TGT_DEV),
        .SLOT_W(SLOT_W), .RIDX_W(RIDX_W)
    ) u_decode (
        .off(req_off), .len(req_len), .legal(legal), .is_root(is_root),
        .hit(hit), .page(page), .slot(slot), .ridx(ridx)
    );

    vreg_store #(
        .NUM_FUNCS(NUM_FUNCS), .SLOT_W(SLOT_W), .RIDX_W(RIDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .present_in(func_present), .wr_en(wr_en),
        .a_slot(slot), .a_page(page), .a_idx(ridx), .wr_data(req_wdata),
        .rd_data(rd_data), .rd_present(rd_present)
    );

    always_comb begin
        wr_en       = req_valid && req_write && legal && !is_root && hit;
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && !legal;
        rsp_d.page  = req_valid && page;
        rsp_d.rdata = '0;
        if (req_valid && !req_write && legal && !is_root && hit && rd_present) begin
            rsp_d.rdata = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_page  = rsp_q.page;
    assign rsp_rdata = rsp_q.rdata;

    // R2: one response, one cycle after each request, none otherwise
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: misaligned or non-dword request is flagged and reads zero
    assert_malformed_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_off[1:0] != 2'b00 || req_len != 3'd4)) |=> (rsp_err && rsp_rdata == '0));

    // R4: the error pulse only rides on a response
    assert_err_with_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R5: host bridge address always reads zero
    assert_root_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_off[28:13] == '0) |=> (rsp_rdata == '0));

    // R8: page bit echoes the request offset
    assert_page_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_page == $past(req_off[12])));
endmodule

// File: tb/tb_vreg_window.sv
`timescale 1ns/1ps
module tb_vreg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  func_present = 4'b1011;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [28:0] req_off = '0;
    logic [2:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, rsp_page;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vreg_window #(.NUM_FUNCS(4), .IMPL_REGS(4), .TGT_DEV(1)) dut (
        .clk(clk), .rst_n(rst_n), .func_present(func_present),
        .req_valid(req_valid), .req_write(req_write), .req_off(req_off),
        .req_len(req_len), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_page(rsp_page)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  len;
        logic [28:0] off;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    // device 1 on bus 0: function f, page p, index i -> 0x10000 | f<<13 | p<<12 | i<<2
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd4, 29'h0010000, 32'hA5A50001, 32'h0, 1'b0, 4'd1},  // R1 f0 p0 i0
        '{1'b1, 3'd4, 29'h0011000, 32'h5A5A0002, 32'h0, 1'b0, 4'd1},  // R1 f0 p1 i0
        '{1'b1, 3'd4, 29'h001200C, 32'h12345678, 32'h0, 1'b0, 4'd1},  // R1 f1 p0 i3
        '{1'b1, 3'd4, 29'h0017008, 32'hDEADBEEF, 32'h0, 1'b0, 4'd1},  // R1 f3 p1 i2
        '{1'b0, 3'd4, 29'h0010000, 32'h0, 32'hA5A50001, 1'b0, 4'd1},  // R1
        '{1'b0, 3'd4, 29'h0011000, 32'h0, 32'h5A5A0002, 1'b0, 4'd1},  // R1
        '{1'b0, 3'd4, 29'h001200C, 32'h0, 32'h12345678, 1'b0, 4'd1},  // R1
        '{1'b0, 3'd4, 29'h0017008, 32'h0, 32'hDEADBEEF, 1'b0, 4'd1},  // R1
        '{1'b0, 3'd4, 29'h0012000, 32'h0, 32'h0, 1'b0, 4'd9},         // R9 unwritten word
        '{1'b1, 3'd4, 29'h0014000, 32'h00001111, 32'h0, 1'b0, 4'd6},  // R6 f2 absent
        '{1'b0, 3'd4, 29'h0014000, 32'h0, 32'h0, 1'b0, 4'd6},         // R6
        '{1'b1, 3'd4, 29'h0000000, 32'h00002222, 32'h0, 1'b0, 4'd5},  // R5 root
        '{1'b0, 3'd4, 29'h0000000, 32'h0, 32'h0, 1'b0, 4'd5},         // R5
        '{1'b1, 3'd4, 29'h0010002, 32'h0000FFFF, 32'h0, 1'b1, 4'd3},  // R3 misaligned write
        '{1'b0, 3'd4, 29'h0010000, 32'h0, 32'hA5A50001, 1'b0, 4'd3},  // R3 not stored
        '{1'b1, 3'd2, 29'h0012000, 32'h00003333, 32'h0, 1'b1, 4'd3},  // R3 short write
        '{1'b0, 3'd4, 29'h0012000, 32'h0, 32'h0, 1'b0, 4'd3},         // R3
        '{1'b0, 3'd1, 29'h001200C, 32'h0, 32'h0, 1'b1, 4'd3},         // R3 byte read
        '{1'b0, 3'd4, 29'h0000001, 32'h0, 32'h0, 1'b1, 4'd3},         // R3 root misaligned
        '{1'b1, 3'd4, 29'h0012010, 32'h00004444, 32'h0, 1'b0, 4'd10}, // R10 index 4
        '{1'b0, 3'd4, 29'h0012010, 32'h0, 32'h0, 1'b0, 4'd10},        // R10
        '{1'b0, 3'd4, 29'h0012000, 32'h0, 32'h0, 1'b0, 4'd10},        // R10 no alias
        '{1'b1, 3'd4, 29'h0210000, 32'h00005555, 32'h0, 1'b0, 4'd6},  // R6 bus 1
        '{1'b0, 3'd4, 29'h0210000, 32'h0, 32'h0, 1'b0, 4'd6},         // R6
        '{1'b0, 3'd4, 29'h0010000, 32'h0, 32'hA5A50001, 1'b0, 4'd6},  // R6 no alias
        '{1'b1, 3'd4, 29'h0018000, 32'h00006666, 32'h0, 1'b0, 4'd6},  // R6 function 4
        '{1'b0, 3'd4, 29'h0018000, 32'h0, 32'h0, 1'b0, 4'd6},         // R6
        '{1'b0, 3'd4, 29'h0010000, 32'h0, 32'hA5A50001, 1'b0, 4'd6},  // R6 no alias
        '{1'b1, 3'd7, 29'h001200C, 32'h00007777, 32'h0, 1'b1, 4'd3},  // R3 len 7
        '{1'b0, 3'd4, 29'h001200C, 32'h0, 32'h12345678, 1'b0, 4'd3}   // R3 kept
    };

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // called just after a falling edge; returns just after the next falling edge
    task automatic access(input logic wr, input logic [2:0] len, input logic [28:0] off,
                          input logic [31:0] wd, input logic [31:0] exp, input logic err,
                          input string tag);
        req_valid = 1'b1; req_write = wr; req_len = len; req_off = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
        check(tag, "rsp_rdata", rsp_rdata, exp);
        check(tag, "rsp_err", 32'(rsp_err), 32'(err));
        check("R8", "rsp_page", 32'(rsp_page), 32'(off[12]));
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        check(tag, "idle rsp_valid", 32'(rsp_valid), 32'd0);
        check(tag, "idle rsp_err", 32'(rsp_err), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R9", "reset rsp_err", 32'(rsp_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "post-reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R9", "post-reset rdata", rsp_rdata, 32'd0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].len, VECS[i].off, VECS[i].wdata,
                   VECS[i].exp, VECS[i].err, $sformatf("R%0d", VECS[i].req));
        end
        // R4: error pulse gone once requests stop
        idle_check("R4");

        // R4: error is a single-cycle pulse between legal accesses
        access(1'b0, 3'd3, 29'h0010000, 32'h0, 32'h0, 1'b1, "R4");
        access(1'b0, 3'd4, 29'h0010000, 32'h0, 32'hA5A50001, 1'b0, "R4");
        idle_check("R2");

        // R7: mask changes outside reset are ignored
        func_present = 4'b1111;
        access(1'b1, 3'd4, 29'h0014000, 32'h0000ABCD, 32'h0, 1'b0, "R7");
        access(1'b0, 3'd4, 29'h0014000, 32'h0, 32'h0, 1'b0, "R7");

        // R7/R9: new mask captured on a second reset, store cleared
        func_present = 4'b0100;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        func_present = 4'b1011;
        @(negedge clk);
        access(1'b0, 3'd4, 29'h001200C, 32'h0, 32'h0, 1'b0, "R9");
        access(1'b1, 3'd4, 29'h0015004, 32'h00C0FFEE, 32'h0, 1'b0, "R7");
        access(1'b0, 3'd4, 29'h0015004, 32'h0, 32'h00C0FFEE, 1'b0, "R7");
        access(1'b1, 3'd4, 29'h0010000, 32'h0BADF00D, 32'h0, 1'b0, "R7");
        access(1'b0, 3'd4, 29'h0010000, 32'h0, 32'h0, 1'b0, "R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule